// File: doc/BRIEF.md
# Out-of-Order Dispatch Queue for Three Execution Units

This block sits between instruction fetch and three execution units: an integer unit, a floating-point unit and a branch unit. Fetch hands it a group of eight pre-decoded instructions at a time. Each instruction carries a class code plus up to two source registers and one destination register. The queue keeps them in program order in a circular store.

Every cycle the dispatch logic scans the queue from oldest to youngest. For each of the three unit ports it offers the oldest instruction of that class that is free of register hazards. An instruction may overtake older ones only when it has no true, anti or output dependence on any older instruction that has not issued yet. It must also touch no register that an issued floating-point or branch instruction still owes a result for.

A scoreboard tracks those owed results. A bit is set on issue and cleared by the completion port. Integer results count as available one cycle after issue, so integer issues never enter the scoreboard.

Top module: `dispatch_queue`

## Requirements
- R1: When `grp_valid` and `grp_ready` are both high at a clock edge, all eight entries of `grp_ent` are queued in one step. Entry 0 is the oldest and entry 7 the youngest.
- R2: `grp_ready` is high exactly when the number of free queue entries is at least eight. With the default 16 entries, it is low while more than eight are occupied.
- R3: An entry has 3*REG_W+5 bits (20 bits for the default 5-bit register identifiers), with these fields:
  - [19:18] class: 0 integer, 1 floating point, 2 branch, 3 also treated as branch
  - [17] destination valid, [16:12] destination
  - [11] source-1 valid, [10:6] source 1
  - [5] source-2 valid, [4:0] source 2

  Class 0 goes only to port 0, class 1 only to port 1, and classes 2 and 3 only to port 2.
- R4 (true dependence): An instruction is not offered while one of its valid sources equals the valid destination of an older unissued entry, or equals a register marked pending in the scoreboard.
- R5 (anti dependence): An instruction is not offered while its valid destination equals a valid source of an older unissued entry.
- R6 (output dependence): An instruction is not offered while its valid destination equals the valid destination of an older unissued entry, or equals a pending register.
- R7 (selection and handshake):
  - Each port offers at most one instruction per cycle: the oldest eligible one of its class.
  - An instruction issues when its port has `iss_valid` and `iss_ready` both high.
  - `iss_valid` does not depend on `iss_ready`. Once raised, it stays high until that port issues.
- R8: A younger instruction with no hazard is offered even while an older instruction of another class, or of the same class, is blocked.
- R9: Issue of a floating-point or branch instruction with a valid destination marks that register pending. A completion (`cmp_valid` with `cmp_reg`) clears the mark. A dependent waiting on the mark is offered in the cycle after the completion.
- R10: An integer issue marks nothing pending. An integer instruction that depends on it is offered in the cycle after that issue.
- R11: A synchronous reset empties the queue and clears the scoreboard. Afterwards `grp_ready` is high and `iss_valid` is zero.
- R12: Issued entries at the old end of the queue are freed at the clock edge of their issue. The freed room shows on `grp_ready` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| grp_valid | input | 1 | Fetch group offered |
| grp_ready | output | 1 | Room for a whole fetch group |
| grp_ent | input | GROUP x (3*REG_W+5) | Fetch group, index 0 oldest |
| iss_valid | output | 3 | Per port: instruction offered (0 integer, 1 floating point, 2 branch) |
| iss_ready | input | 3 | Per port: unit accepts |
| iss_ent | output | 3 x (3*REG_W+5) | Per port: offered entry |
| cmp_valid | input | 1 | Completion of a pending register write |
| cmp_reg | input | REG_W | Register whose write completed |

## Verification
A completion and an issue can fall in the same cycle. The bench provokes this by holding a consumer of a pending register while a branch issues on its own port and the completion arrives on the same edge. It then checks that the consumer shows on the floating-point port only one cycle later.

Issue and reclaim also coincide with a full queue. The bench fills all sixteen entries and issues on all ports for several cycles, then judges the exact cycle in which `grp_ready` returns against a hand count of the entries freed at the old end. A sweep over no, true, anti and output hazard between two instructions judges whether the younger one is offered, before and after the older one issues and completes.

// File: rtl/dq_pkg.sv
package dq_pkg;
    localparam int NPORT = 3;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_FP  = 2'd1,
        CLS_BR  = 2'd2,
        CLS_RSV = 2'd3
    } cls_e;

    // Reserved class code is routed to the branch port.
    function automatic logic [1:0] port_of(input logic [1:0] cls);
        return (cls == CLS_RSV) ? 2'(CLS_BR) : cls;
    endfunction
endpackage

// File: rtl/dq_ring.sv
module dq_ring #(
    parameter int DEPTH = 16,
    parameter int GROUP = 8,
    parameter int EW    = 20,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [GROUP-1:0][EW-1:0]   wr_data,
    input  logic [DEPTH-1:0]           fire_slot,
    output logic [DEPTH-1:0][EW-1:0]   slot_q,
    output logic [DEPTH-1:0]           done_q,
    output logic [PW-1:0]              head_q,
    output logic [CW-1:0]              cnt_q
);
    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] slot;
        logic [DEPTH-1:0]         done;
        logic [PW-1:0]            head;
        logic [CW-1:0]            cnt;
    } ring_t;

    ring_t s_d, s_q;

    always_comb begin
        logic          run;
        logic [CW-1:0] rc;
        logic [PW-1:0] idx;
        s_d      = s_q;
        s_d.done = s_q.done | fire_slot;
        run      = 1'b1;
        rc       = '0;
        idx      = '0;
        // free the run of issued entries at the old end
        for (int k = 0; k < DEPTH; k++) begin
            idx = s_q.head + PW'(k);
            if (run && (k < int'(s_q.cnt)) && s_d.done[idx]) begin
                rc            = rc + 1'b1;
                s_d.done[idx] = 1'b0;
            end else begin
                run = 1'b0;
            end
        end
        if (wr_en) begin
            for (int g = 0; g < GROUP; g++) begin
                idx           = s_q.head + PW'(int'(s_q.cnt)) + PW'(g);
                s_d.slot[idx] = wr_data[g];
                s_d.done[idx] = 1'b0;
            end
        end
        s_d.head = s_q.head + PW'(rc);
        s_d.cnt  = s_q.cnt - rc + (wr_en ? CW'(GROUP) : CW'(0));
        if (rst) s_d = '0;
    end

    always_ff @(posedge clk) s_q <= s_d;

    assign slot_q = s_q.slot;
    assign done_q = s_q.done;
    assign head_q = s_q.head;
    assign cnt_q  = s_q.cnt;

    AST_FILL_GROUP: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> int'(cnt_q) >= GROUP);                                  // R1
    AST_FIRE_LIVE: assert property (@(posedge clk) disable iff (rst)
        (fire_slot & done_q) == '0);                                      // R7
endmodule

// File: rtl/dq_pick.sv
module dq_pick
    import dq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int REG_W = 5,
    parameter int EW    = 3 * REG_W + 5,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int NREG  = 1 << REG_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [DEPTH-1:0][EW-1:0]  slot_q,
    input  logic [DEPTH-1:0]          done_q,
    input  logic [PW-1:0]             head_q,
    input  logic [CW-1:0]             cnt_q,
    input  logic [NREG-1:0]           pend,
    input  logic [NPORT-1:0]          port_rdy,
    output logic [NPORT-1:0]          port_vld,
    output logic [NPORT-1:0][EW-1:0]  port_ent,
    output logic [DEPTH-1:0]          fire_slot
);
    localparam int S2_LSB = 0;
    localparam int S2V    = REG_W;
    localparam int S1_LSB = REG_W + 1;
    localparam int S1V    = 2 * REG_W + 1;
    localparam int D_LSB  = 2 * REG_W + 2;
    localparam int DV     = 3 * REG_W + 2;
    localparam int C_LSB  = 3 * REG_W + 3;

    function automatic logic reads(input logic [EW-1:0] e, input logic [REG_W-1:0] r);
        return (e[S1V] && e[S1_LSB +: REG_W] == r) || (e[S2V] && e[S2_LSB +: REG_W] == r);
    endfunction

    // hazard between an older unissued entry and a younger candidate
    function automatic logic hazard(input logic [EW-1:0] o, input logic [EW-1:0] y);
        logic raw, war, waw;
        raw = o[DV] && reads(y, o[D_LSB +: REG_W]);
        war = y[DV] && reads(o, y[D_LSB +: REG_W]);
        waw = y[DV] && o[DV] && (y[D_LSB +: REG_W] == o[D_LSB +: REG_W]);
        return raw || war || waw;
    endfunction

    function automatic logic pend_hit(input logic [EW-1:0] e, input logic [NREG-1:0] p);
        return (e[S1V] && p[e[S1_LSB +: REG_W]]) || (e[S2V] && p[e[S2_LSB +: REG_W]]) ||
               (e[DV] && p[e[D_LSB +: REG_W]]);
    endfunction

    logic [DEPTH-1:0][EW-1:0] ord;
    logic [DEPTH-1:0]         live;
    logic [DEPTH-1:0]         ok;
    logic [NPORT-1:0][PW-1:0] sel;

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            ord[k]  = slot_q[head_q + PW'(k)];
            live[k] = (k < int'(cnt_q)) && !done_q[head_q + PW'(k)];
        end
        for (int k = 0; k < DEPTH; k++) begin
            ok[k] = live[k] && !pend_hit(ord[k], pend);
            for (int j = 0; j < DEPTH; j++) begin
                if (j < k && live[j] && hazard(ord[j], ord[k])) ok[k] = 1'b0;
            end
        end
        fire_slot = '0;
        for (int c = 0; c < NPORT; c++) begin
            port_vld[c] = 1'b0;
            sel[c]      = '0;
            for (int k = 0; k < DEPTH; k++) begin
                if (!port_vld[c] && ok[k] && port_of(ord[k][C_LSB +: 2]) == 2'(c)) begin
                    port_vld[c] = 1'b1;
                    sel[c]      = PW'(k);
                end
            end
            port_ent[c] = ord[sel[c]];
            if (port_vld[c] && port_rdy[c]) fire_slot[head_q + sel[c]] = 1'b1;
        end
    end

    for (genvar c = 0; c < NPORT; c++) begin : g_chk
        AST_PORT_CLASS: assert property (@(posedge clk) disable iff (rst)
            port_vld[c] |-> port_of(port_ent[c][C_LSB +: 2]) == 2'(c));                  // R3
        AST_SRC_FREE: assert property (@(posedge clk) disable iff (rst)
            (port_vld[c] && port_ent[c][S1V]) |-> !pend[port_ent[c][S1_LSB +: REG_W]]); // R4
        AST_DST_FREE: assert property (@(posedge clk) disable iff (rst)
            (port_vld[c] && port_ent[c][DV]) |-> !pend[port_ent[c][D_LSB +: REG_W]]);   // R6
        AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
            (port_vld[c] && !port_rdy[c]) |=> port_vld[c]);                              // R7
    end
endmodule

// File: rtl/dq_score.sv
module dq_score
    import dq_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int EW    = 3 * REG_W + 5,
    parameter int NREG  = 1 << REG_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORT-1:0]         fire,
    input  logic [NPORT-1:0][EW-1:0] ent,
    input  logic                     clr_vld,
    input  logic [REG_W-1:0]         clr_reg,
    output logic [NREG-1:0]          pend_q
);
    localparam int D_LSB = 2 * REG_W + 2;
    localparam int DV    = 3 * REG_W + 2;

    typedef struct packed {
        logic [NREG-1:0] pend;
    } sb_t;

    sb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_vld) s_d.pend[clr_reg] = 1'b0;
        // integer port (0) is released one cycle after issue: never marked
        for (int c = 1; c < NPORT; c++) begin
            if (fire[c] && ent[c][DV]) s_d.pend[ent[c][D_LSB +: REG_W]] = 1'b1;
        end
        if (rst) s_d = '0;
    end

    always_ff @(posedge clk) s_q <= s_d;

    assign pend_q = s_q.pend;

    AST_SB_SET_FP: assert property (@(posedge clk) disable iff (rst)
        (fire[1] && ent[1][DV]) |=> pend_q[$past(ent[1][D_LSB +: REG_W])]);             // R9
    AST_SB_SET_BR: assert property (@(posedge clk) disable iff (rst)
        (fire[2] && ent[2][DV]) |=> pend_q[$past(ent[2][D_LSB +: REG_W])]);             // R9
    AST_SB_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_vld && !(fire[1] && ent[1][DV] && ent[1][D_LSB +: REG_W] == clr_reg)
                 && !(fire[2] && ent[2][DV] && ent[2][D_LSB +: REG_W] == clr_reg))
        |=> !pend_q[$past(clr_reg)]);                                                    // R9
    AST_INT_FREE: assert property (@(posedge clk) disable iff (rst)
        (fire[0] && ent[0][DV]) |=> !pend_q[$past(ent[0][D_LSB +: REG_W])]);            // R10
    AST_SB_RESET: assert property (@(posedge clk)
        rst |=> pend_q == '0);                                                           // R11
endmodule

// File: rtl/dispatch_queue.sv
module dispatch_queue
    import dq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int GROUP = 8,
    parameter int REG_W = 5
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              grp_valid,
    output logic                              grp_ready,
    input  logic [GROUP-1:0][3*REG_W+4:0]     grp_ent,
    output logic [2:0]                        iss_valid,
    input  logic [2:0]                        iss_ready,
    output logic [2:0][3*REG_W+4:0]           iss_ent,
    input  logic                              cmp_valid,
    input  logic [REG_W-1:0]                  cmp_reg
);
    localparam int EW   = 3 * REG_W + 5;
    localparam int PW   = $clog2(DEPTH);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int NREG = 1 << REG_W;

    logic [DEPTH-1:0][EW-1:0] slot_q;
    logic [DEPTH-1:0]         done_q;
    logic [PW-1:0]            head_q;
    logic [CW-1:0]            cnt_q;
    logic [DEPTH-1:0]         fire_slot;
    logic [NREG-1:0]          pend_q;
    logic                     wr_en;

    assign grp_ready = (int'(cnt_q) + GROUP) <= DEPTH;
    assign wr_en     = grp_valid && grp_ready;

    dq_ring #(.DEPTH(DEPTH), .GROUP(GROUP), .EW(EW), .PW(PW), .CW(CW)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (grp_ent),
        .fire_slot(fire_slot),
        .slot_q   (slot_q),
        .done_q   (done_q),
        .head_q   (head_q),
        .cnt_q    (cnt_q)
    );

    dq_pick #(.DEPTH(DEPTH), .REG_W(REG_W), .EW(EW), .PW(PW), .CW(CW), .NREG(NREG)) u_pick (
        .clk      (clk),
        .rst      (rst),
        .slot_q   (slot_q),
        .done_q   (done_q),
        .head_q   (head_q),
        .cnt_q    (cnt_q),
        .pend     (pend_q),
        .port_rdy (iss_ready),
        .port_vld (iss_valid),
        .port_ent (iss_ent),
        .fire_slot(fire_slot)
    );

    dq_score #(.REG_W(REG_W), .EW(EW), .NREG(NREG)) u_score (
        .clk    (clk),
        .rst    (rst),
        .fire   (iss_valid & iss_ready),
        .ent    (iss_ent),
        .clr_vld(cmp_valid),
        .clr_reg(cmp_reg),
        .pend_q (pend_q)
    );

    AST_RST_EMPTY: assert property (@(posedge clk)
        rst |=> (grp_ready && iss_valid == 3'b000));                     // R11
    AST_ROOM_GATE: assert property (@(posedge clk) disable iff (rst)
        (grp_valid && grp_ready) |=> !(int'(cnt_q) > DEPTH));             // R2
endmodule

// File: tb/tb_dispatch_queue.sv
module tb_dispatch_queue;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              grp_valid = 1'b0;
    logic              grp_ready;
    logic [7:0][19:0]  grp_ent = '0;
    logic [2:0]        iss_valid;
    logic [2:0]        iss_ready = 3'b000;
    logic [2:0][19:0]  iss_ent;
    logic              cmp_valid = 1'b0;
    logic [4:0]        cmp_reg = '0;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dispatch_queue dut (
        .clk(clk), .rst(rst),
        .grp_valid(grp_valid), .grp_ready(grp_ready), .grp_ent(grp_ent),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_ent(iss_ent),
        .cmp_valid(cmp_valid), .cmp_reg(cmp_reg)
    );

    function automatic logic [19:0] mk(input int c, input int dv, input int d,
                                       input int s1v, input int s1, input int s2v, input int s2);
        return {2'(c), 1'(dv), 5'(d), 1'(s1v), 5'(s1), 1'(s2v), 5'(s2)};
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic push(input logic [7:0][19:0] g);
        grp_ent   = g;
        grp_valid = 1'b1;
        @(negedge clk);
        grp_valid = 1'b0;
        #1;
    endtask

    task automatic cyc(input logic [2:0] rdy, input logic cv, input logic [4:0] cr);
        iss_ready = rdy;
        cmp_valid = cv;
        cmp_reg   = cr;
        @(negedge clk);
        iss_ready = 3'b000;
        cmp_valid = 1'b0;
        #1;
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [19:0]      nop;
        logic [7:0][19:0] a;
        logic [7:0][19:0] g;
        nop = mk(2, 0, 0, 0, 0, 0, 0);

        // ---------------- reset state
        do_reset();
        chk("R11 ready after reset", 32'(grp_ready), 32'd1);
        chk("R11 no issue after reset", 32'(iss_valid), 32'd0);

        // ---------------- mixed group with hazards
        a[0] = mk(1, 1, 1, 1, 2, 1, 3);
        a[1] = mk(0, 1, 4, 1, 1, 0, 0);
        a[2] = mk(0, 1, 5, 1, 6, 0, 0);
        a[3] = mk(2, 1, 7, 0, 0, 0, 0);
        a[4] = mk(0, 1, 2, 1, 8, 0, 0);
        a[5] = mk(1, 1, 1, 1, 9, 0, 0);
        a[6] = mk(0, 1, 10, 1, 11, 0, 0);
        a[7] = mk(1, 1, 12, 1, 13, 0, 0);
        push(a);
        chk("R1 group visible", 32'(iss_valid), 32'd7);
        chk("R8 younger int passes blocked one", 32'(iss_ent[0]), 32'(a[2]));
        chk("R3 fp port", 32'(iss_ent[1]), 32'(a[0]));
        chk("R3 branch port", 32'(iss_ent[2]), 32'(a[3]));
        chk("R2 eight free", 32'(grp_ready), 32'd1);
        cyc(3'b000, 1'b0, 5'd0);
        chk("R7 offer held", 32'(iss_ent[0]), 32'(a[2]));
        cyc(3'b001, 1'b0, 5'd0);
        chk("R4 R5 skip raw and war", 32'(iss_ent[0]), 32'(a[6]));
        cyc(3'b010, 1'b0, 5'd0);
        chk("R6 waw on pending", 32'(iss_ent[1]), 32'(a[7]));
        chk("R5 war cleared by issue", 32'(iss_ent[0]), 32'(a[4]));
        chk("R7 branch held", 32'(iss_ent[2]), 32'(a[3]));
        cyc(3'b000, 1'b1, 5'd1);
        chk("R9 consumer after completion", 32'(iss_ent[0]), 32'(a[1]));
        chk("R5 war versus older reader", 32'(iss_ent[1]), 32'(a[7]));
        cyc(3'b111, 1'b0, 5'd0);
        chk("R7 ports after triple issue", 32'(iss_valid), 32'd3);
        chk("R7 oldest int", 32'(iss_ent[0]), 32'(a[4]));
        chk("R7 oldest fp", 32'(iss_ent[1]), 32'(a[5]));
        cyc(3'b011, 1'b0, 5'd0);
        chk("R7 last int", 32'(iss_valid), 32'd1);
        chk("R7 last int entry", 32'(iss_ent[0]), 32'(a[6]));
        cyc(3'b001, 1'b0, 5'd0);
        chk("R12 drained", 32'(iss_valid), 32'd0);

        // ---------------- completion coinciding with an issue (r12 pending)
        g = {8{nop}};
        g[0] = mk(1, 0, 0, 1, 12, 0, 0);
        push(g);
        chk("R4 source pending", 32'(iss_valid), 32'd4);
        cyc(3'b100, 1'b1, 5'd12);
        chk("R9 released same edge as branch issue", 32'(iss_valid), 32'd6);

        // ---------------- reset with work outstanding (r1, r7 pending)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 queue emptied", 32'(iss_valid), 32'd0);
        chk("R11 room restored", 32'(grp_ready), 32'd1);
        g = {8{nop}};
        g[0] = mk(0, 1, 1, 1, 7, 0, 0);
        push(g);
        chk("R11 scoreboard cleared", 32'(iss_ent[0]), 32'(g[0]));

        // ---------------- hazard sweep: none, true, anti, output
        for (int kind = 0; kind < 4; kind++) begin
            logic [19:0] yng;
            do_reset();
            case (kind)
                0: yng = mk(0, 1, 8, 1, 9, 0, 0);
                1: yng = mk(0, 1, 8, 0, 0, 1, 1);
                2: yng = mk(0, 1, 3, 1, 9, 0, 0);
                default: yng = mk(0, 1, 1, 1, 9, 0, 0);
            endcase
            g = {8{nop}};
            g[0] = mk(1, 1, 1, 1, 2, 1, 3);
            g[1] = yng;
            push(g);
            chk($sformatf("R8 R4 R5 R6 kind %0d before", kind),
                32'(iss_valid[0]), 32'(kind == 0));
            cyc(3'b010, 1'b0, 5'd0);
            chk($sformatf("R4 R5 R6 kind %0d after issue", kind),
                32'(iss_valid[0]), 32'(kind == 0 || kind == 2));
            cyc(3'b000, 1'b1, 5'd1);
            chk($sformatf("R9 kind %0d after completion", kind),
                32'(iss_ent[0]), 32'(yng));
        end

        // ---------------- integer chain and full-queue reclaim
        do_reset();
        g = {8{nop}};
        g[0] = mk(0, 1, 20, 0, 0, 0, 0);
        g[1] = mk(0, 1, 21, 1, 20, 0, 0);
        g[2] = mk(0, 1, 22, 1, 21, 0, 0);
        push(g);
        a = g;
        g = {8{nop}};
        push(g);
        chk("R2 full queue", 32'(grp_ready), 32'd0);
        chk("R1 oldest first", 32'(iss_ent[0]), 32'(a[0]));
        iss_ready = 3'b111;
        @(negedge clk);
        #1;
        chk("R10 chain step one", 32'(iss_ent[0]), 32'(a[1]));
        @(negedge clk);
        #1;
        chk("R10 chain step two", 32'(iss_ent[0]), 32'(a[2]));
        @(negedge clk);
        #1;
        chk("R12 still full after three", 32'(grp_ready), 32'd0);
        @(negedge clk);
        #1;
        chk("R12 nine held after four", 32'(grp_ready), 32'd0);
        @(negedge clk);
        #1;
        chk("R12 room after five", 32'(grp_ready), 32'd1);
        iss_ready = 3'b000;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule